// File: doc/BRIEF.md
# I2C Register-Read Target

This block is an I2C target that serves register reads from a small register file through an internal address pointer. It watches SCL and SDA, both brought into the system clock domain by synchronizers. It detects START, repeated START and STOP. It matches a 7-bit target address and acknowledges it by pulling SDA low through its open-drain enable.

Two read forms are supported. In a current-address read the controller sends the address with R/W=1 and receives bytes beginning at the stored pointer. In a random read the controller first sends a write-direction address followed by a register address byte, which loads the pointer. It then issues a repeated START and a read-direction address.

Each transmitted byte advances the pointer along a sparse map. The low window steps through 00h–03h, jumps to 10h, runs to 18h and wraps to 00h. The high window cycles 30h–32h on its own. Register data arrives combinationally on `reg_data_i` for the address presented on `reg_addr_o`. The system clock must run at least eight times the SCL rate.

Top module: `i2c_rd_target`

## Requirements
- R1: A START (SDA falling while SCL is high) restarts target-address reception from any state, including mid-byte. A STOP (SDA rising while SCL is high) returns the block to idle with SDA released. Neither event changes the pointer.
- R2: The first byte after a START carries the 7-bit target address MSB first, followed by the R/W bit. On a match, SDA is pulled low through the ninth SCL clock. On a mismatch, SDA stays released for the whole transaction and the pointer is unchanged.
- R3: With R/W=1, the block returns the register at the pointer MSB first. The first data bit is driven after the SCL fall that ends the address ACK clock.
- R4: With R/W=0, the next byte is a register address. If it is in the map, it is acknowledged and loaded into the pointer, and a following repeated START with R/W=1 returns that register first.
- R5: In the low window the pointer advances by one, except that 03h steps to 10h and 18h wraps to 00h.
- R6: In the high window the pointer steps 30h, 31h, 32h and then wraps to 30h.
- R7: `reg_addr_o` shows the pointer, which holds the address after the last transmitted byte. It changes only when a byte is loaded for transmission or a register address is accepted.
- R8: A register address outside 00h–18h and 30h–32h (for example 19h or 20h) is not acknowledged, and the pointer keeps its value.
- R9: An ACK from the controller after a data byte makes the block send the next sequential byte. After a NACK the block releases SDA and drives nothing until the next START.
- R10: The SDA output enable changes only while SCL is low, apart from the release on START or STOP. SDA is released during the controller's ACK/NACK bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| reg_addr_o | output | 8 | Register read address (pointer) |
| reg_data_i | input | 8 | Register data for `reg_addr_o` |

## Verification
The bench builds the block with target address 4Dh and the default windows (03h to 10h, 18h to 00h, 32h to 30h) and two synchronizer stages. With those windows every jump and wrap of the pointer is reachable in reads of three or four bytes. The target address has both 0 and 1 bits, so a single flipped address bit exercises the mismatch path. SCL runs at ten system clocks per half period, which keeps the synchronizer delay within the low phase while still testing that output changes land there.

// File: rtl/i2c_rd_pkg.sv
`timescale 1ns/1ps
package i2c_rd_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CNT_W  = $clog2(DATA_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_TX,
    ST_TX_ACK
  } st_e;
endpackage

// File: rtl/i2c_rd_line_sync.sv
`timescale 1ns/1ps
module i2c_rd_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_i;
          sda_ff[g] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_ff[g-1];
          sda_ff[g] <= sda_ff[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_o;
      sda_q <= sda_o;
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edge while SCL stays high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_rd_ptr.sv
`timescale 1ns/1ps
module i2c_rd_ptr
  import i2c_rd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] LO_END    = 8'h03,
  parameter logic [ADDR_W-1:0] MID_START = 8'h10,
  parameter logic [ADDR_W-1:0] MID_END   = 8'h18,
  parameter logic [ADDR_W-1:0] HI_START  = 8'h30,
  parameter logic [ADDR_W-1:0] HI_END    = 8'h32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              addr_ok_o
);
  function automatic logic in_map(input logic [ADDR_W-1:0] a);
    return (a <= MID_END) || ((a >= HI_START) && (a <= HI_END));
  endfunction

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a);
    if (a == LO_END)  return MID_START;
    if (a == MID_END) return '0;
    if (a == HI_END)  return HI_START;
    return a + 1'b1;
  endfunction

  assign addr_ok_o = in_map(load_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_addr_i;
    else if (adv_i)  ptr_o <= step(ptr_o);
  end
endmodule

// File: rtl/i2c_rd_fsm.sv
`timescale 1ns/1ps
module i2c_rd_fsm
  import i2c_rd_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h0C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [DATA_W-1:0] reg_data_i,
  input  logic              addr_ok_i,
  output logic              sda_oe_o,
  output logic              load_o,
  output logic [ADDR_W-1:0] load_addr_o,
  output logic              adv_o,
  output st_e               st_o
);
  st_e               st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rx_sh, tx_sh;
  logic              rw_q, ack_q, drv_ack;
  logic              byte_end, tx_load;

  assign byte_end = scl_fall_i && (cnt == CNT_W'(DATA_W));
  assign tx_load  = scl_fall_i && !start_i && !stop_i &&
                    (((st == ST_DEV_ACK) && rw_q) || ((st == ST_TX_ACK) && ack_q));
  assign adv_o       = tx_load;
  assign load_o      = byte_end && (st == ST_REG) && addr_ok_i;
  assign load_addr_o = rx_sh;
  assign sda_oe_o    = (st == ST_TX) ? ~tx_sh[DATA_W-1] : drv_ack;
  assign st_o        = st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      rw_q    <= 1'b0;
      ack_q   <= 1'b0;
      drv_ack <= 1'b0;
    end else if (start_i) begin
      st      <= ST_DEV;
      cnt     <= '0;
      drv_ack <= 1'b0;
    end else if (stop_i) begin
      st      <= ST_IDLE;
      drv_ack <= 1'b0;
    end else begin
      unique case (st)
        ST_DEV, ST_REG: begin
          if (scl_rise_i) begin
            rx_sh <= {rx_sh[DATA_W-2:0], sda_s_i};
            cnt   <= cnt + 1'b1;
          end else if (byte_end) begin
            cnt <= '0;
            if (st == ST_DEV) begin
              if (rx_sh[DATA_W-1:1] == TGT_ADDR) begin
                st      <= ST_DEV_ACK;
                drv_ack <= 1'b1;
                rw_q    <= rx_sh[0];
              end else begin
                st <= ST_IDLE;
              end
            end else if (addr_ok_i) begin
              st      <= ST_REG_ACK;
              drv_ack <= 1'b1;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall_i) begin
            drv_ack <= 1'b0;
            cnt     <= '0;
            if (rw_q) begin
              st    <= ST_TX;
              tx_sh <= reg_data_i;
            end else begin
              st <= ST_REG;
            end
          end
        end
        ST_REG_ACK: begin
          // wait for repeated START; further write bytes are ignored
          if (scl_fall_i) begin
            st      <= ST_IDLE;
            drv_ack <= 1'b0;
          end
        end
        ST_TX: begin
          if (scl_rise_i) begin
            cnt <= cnt + 1'b1;
          end else if (byte_end) begin
            st  <= ST_TX_ACK;
            cnt <= '0;
          end else if (scl_fall_i) begin
            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_i) begin
            ack_q <= ~sda_s_i;
          end else if (scl_fall_i) begin
            if (ack_q) begin
              st    <= ST_TX;
              tx_sh <= reg_data_i;
              cnt   <= '0;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_rd_target.sv
`timescale 1ns/1ps
module i2c_rd_target
  import i2c_rd_pkg::*;
#(
  parameter logic [6:0]        TGT_ADDR    = 7'h0C,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] LO_END      = 8'h03,
  parameter logic [ADDR_W-1:0] MID_START   = 8'h10,
  parameter logic [ADDR_W-1:0] MID_END     = 8'h18,
  parameter logic [ADDR_W-1:0] HI_START    = 8'h30,
  parameter logic [ADDR_W-1:0] HI_END      = 8'h32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  input  logic [DATA_W-1:0] reg_data_i
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic              load, adv, addr_ok;
  logic [ADDR_W-1:0] load_addr, ptr;
  st_e               st;

  i2c_rd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_p),
    .stop_o     (stop_p)
  );

  i2c_rd_fsm #(.TGT_ADDR(TGT_ADDR)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sda_s_i     (sda_s),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_p),
    .stop_i      (stop_p),
    .reg_data_i  (reg_data_i),
    .addr_ok_i   (addr_ok),
    .sda_oe_o    (sda_oe_o),
    .load_o      (load),
    .load_addr_o (load_addr),
    .adv_o       (adv),
    .st_o        (st)
  );

  i2c_rd_ptr #(
    .LO_END    (LO_END),
    .MID_START (MID_START),
    .MID_END   (MID_END),
    .HI_START  (HI_START),
    .HI_END    (HI_END)
  ) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_addr_i (load_addr),
    .adv_i       (adv),
    .ptr_o       (ptr),
    .addr_ok_o   (addr_ok)
  );

  assign reg_addr_o = ptr;
endmodule

// File: rtl/i2c_rd_target_chk.sv
`timescale 1ns/1ps
module i2c_rd_target_chk
  import i2c_rd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] LO_END    = 8'h03,
  parameter logic [ADDR_W-1:0] MID_START = 8'h10,
  parameter logic [ADDR_W-1:0] MID_END   = 8'h18,
  parameter logic [ADDR_W-1:0] HI_START  = 8'h30,
  parameter logic [ADDR_W-1:0] HI_END    = 8'h32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s_i,
  input logic              start_i,
  input logic              stop_i,
  input logic              sda_oe_i,
  input logic              adv_i,
  input logic              load_i,
  input logic [ADDR_W-1:0] ptr_i,
  input st_e               st_i
);
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stop_i) |-> (st_i == ST_IDLE)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE) |-> !sda_oe_i); // R9

  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_i) && !$past(start_i) && !$past(stop_i)) |-> !scl_s_i); // R10

  AST_PTR_IN_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_i <= MID_END) || ((ptr_i >= HI_START) && (ptr_i <= HI_END))); // R8

  AST_LO_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(adv_i) && ($past(ptr_i) == LO_END)) |-> (ptr_i == MID_START)); // R5

  AST_LO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(adv_i) && ($past(ptr_i) == MID_END)) |-> (ptr_i == '0)); // R5

  AST_HI_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(adv_i) && ($past(ptr_i) == HI_END)) |-> (ptr_i == HI_START)); // R6

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(adv_i) && !$past(load_i)) |-> $stable(ptr_i)); // R7
endmodule

bind i2c_rd_target i2c_rd_target_chk #(
  .LO_END    (LO_END),
  .MID_START (MID_START),
  .MID_END   (MID_END),
  .HI_START  (HI_START),
  .HI_END    (HI_END)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_s_i  (scl_s),
  .start_i  (start_p),
  .stop_i   (stop_p),
  .sda_oe_i (sda_oe_o),
  .adv_i    (adv),
  .load_i   (load),
  .ptr_i    (ptr),
  .st_i     (st)
);

// File: tb/i2c_rd_target_test.sv
`timescale 1ns/1ps
module i2c_rd_target_test;
  localparam logic [6:0] TGT = 7'h4D;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       ctl_sda = 1'b1;
  logic       sda_oe;
  logic       sda_line;
  logic [7:0] raddr, rdata;

  always #10 clk = ~clk;

  function automatic logic [7:0] dat(input logic [7:0] a);
    return {a[3:0], a[7:4]} ^ 8'h69;
  endfunction

  function automatic logic [7:0] nxt(input logic [7:0] a);
    if (a == 8'h03) return 8'h10;
    if (a == 8'h18) return 8'h00;
    if (a == 8'h32) return 8'h30;
    return a + 8'h01;
  endfunction

  assign sda_line = ctl_sda & ~sda_oe;
  assign rdata    = dat(raddr);

  i2c_rd_target #(.TGT_ADDR(TGT)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .reg_addr_o (raddr),
    .reg_data_i (rdata)
  );

  int         errs = 0;
  int         checks = 0;
  bit         done = 1'b0;
  logic [7:0] model_ptr = 8'h00;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got;
  event       got_ev;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: compares each received byte against the scoreboard
  initial begin
    forever begin
      @(got_ev);
      if (exp_q.size() == 0) chk(1'b0, "R3", "unexpected byte", got, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(got == e, t, "read byte", got, e);
      end
    end
  end

  task automatic start_c();
    ctl_sda = 1'b1; #100; scl = 1'b1; #100; ctl_sda = 1'b0; #100; scl = 1'b0;
  endtask

  task automatic stop_c();
    #100 ctl_sda = 1'b0; #100 scl = 1'b1; #100 ctl_sda = 1'b1; #200;
  endtask

  task automatic wbit(input logic b);
    #100 ctl_sda = b; #100 scl = 1'b1; #200 scl = 1'b0;
  endtask

  task automatic rbit(output logic b);
    #100 ctl_sda = 1'b1; #100 scl = 1'b1; #100 b = sda_line; #100 scl = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(input logic last);
    logic [7:0] v;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      v[i] = b;
    end
    got = v;
    ->got_ev;
    #100 ctl_sda = last; #100 scl = 1'b1;
    #100 chk(sda_oe == 1'b0, "R10", "released in controller ack bit", sda_oe, 0);
    #100 scl = 1'b0;
  endtask

  task automatic push_exp(input logic [7:0] a0, input int n, input string tag);
    logic [7:0] a;
    a = a0;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(dat(a));
      tag_q.push_back(tag);
      a = nxt(a);
    end
    model_ptr = a;
  endtask

  task automatic cur_read(input int n, input string tag);
    logic ack;
    push_exp(model_ptr, n, tag);
    start_c();
    wbyte({TGT, 1'b1}, ack);
    chk(ack, "R2", "read address ack", ack, 1);
    for (int i = 0; i < n; i++) rbyte(i == n - 1);
    stop_c();
    chk(raddr == model_ptr, "R7", "pointer after read", raddr, model_ptr);
    chk(sda_oe == 1'b0, "R9", "released after nack", sda_oe, 0);
  endtask

  task automatic rnd_read(input logic [7:0] a, input int n, input string tag);
    logic ack;
    push_exp(a, n, tag);
    start_c();
    wbyte({TGT, 1'b0}, ack);
    chk(ack, "R2", "write address ack", ack, 1);
    wbyte(a, ack);
    chk(ack, "R4", "register address ack", ack, 1);
    start_c();
    wbyte({TGT, 1'b1}, ack);
    chk(ack, "R4", "read address ack after rs", ack, 1);
    for (int i = 0; i < n; i++) rbyte(i == n - 1);
    stop_c();
    chk(raddr == model_ptr, "R7", "pointer after random read", raddr, model_ptr);
  endtask

  task automatic bad_reg(input logic [7:0] a);
    logic ack;
    start_c();
    wbyte({TGT, 1'b0}, ack);
    chk(ack, "R2", "write address ack", ack, 1);
    wbyte(a, ack);
    chk(!ack, "R8", "out-of-map address nack", ack, 0);
    stop_c();
    chk(raddr == model_ptr, "R8", "pointer kept", raddr, model_ptr);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic ack, b, quiet;
    repeat (5) @(posedge clk);
    #5 chk(sda_oe == 1'b0, "R1", "reset sda released", sda_oe, 0);
    chk(raddr == 8'h00, "R7", "reset pointer", raddr, 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);

    cur_read(3, "R3");             // 00 01 02
    cur_read(3, "R5");             // 03 10 11
    rnd_read(8'h17, 3, "R5");      // 17 18 00
    rnd_read(8'h31, 4, "R6");      // 31 32 30 31
    cur_read(2, "R6");             // 32 30
    rnd_read(8'h08, 3, "R4");      // 08 09 0a

    bad_reg(8'h20);
    bad_reg(8'h19);
    cur_read(1, "R8");             // continues from 0b

    // mismatched target address: no ack, line stays high
    start_c();
    wbyte({TGT ^ 7'h01, 1'b1}, ack);
    chk(!ack, "R2", "mismatch nack", ack, 0);
    quiet = 1'b1;
    for (int i = 0; i < 9; i++) begin
      rbit(b);
      quiet &= b;
    end
    chk(quiet, "R2", "silent after mismatch", quiet, 1);
    stop_c();
    chk(raddr == model_ptr, "R2", "pointer after mismatch", raddr, model_ptr);

    // NACK then more clocks without STOP: nothing driven
    push_exp(model_ptr, 1, "R9");
    start_c();
    wbyte({TGT, 1'b1}, ack);
    chk(ack, "R2", "read address ack", ack, 1);
    rbyte(1'b1);
    quiet = 1'b1;
    for (int i = 0; i < 9; i++) begin
      rbit(b);
      quiet &= b;
    end
    chk(quiet, "R9", "no drive after nack", quiet, 1);
    stop_c();

    // START in mid-byte restarts address reception
    start_c();
    for (int i = 6; i >= 3; i--) wbit(TGT[i]);
    cur_read(2, "R1");

    repeat (20) @(posedge clk);
    chk(exp_q.size() == 0, "R3", "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule